// File: doc/BRIEF.md
# Selectable Card Clock Divider

This block derives the clock sent to a smart card from a reference clock. Two select inputs choose one of four ratios: the reference itself, or the reference divided by 2, 4 or 8. The code on the select pair is taken as the starting ratio when the sequencer raises its enable. While the card session runs, the host may retarget the ratio at any time. The divider filters the new code through a synchroniser and applies it only on a half-period boundary of the output, so the card never sees a shortened pulse.

A source-type flag selects between two output phases. When the reference comes from a crystal, output edges line up with rising reference edges. When the reference comes from an external driver, the output is the inverted form, and its rising edges line up with falling reference edges. The flag and the enable come from the activation sequencer. Detecting which kind of source is present is done elsewhere.

Top module: `card_clk_div`

## Requirements
- R1: The select code, read as {sel_div[1], sel_div[0]}, sets the ratio: 2'b00 divides by 8, 2'b01 by 4, 2'b11 by 2 and 2'b10 passes the reference through. The output period is the ratio times the reference period, and a divided output has a 50% duty cycle.
- R2: While clk_en is low, card_clk is low from one reference period after clk_en is first sampled low, and the divider restarts from a cleared count.
- R3: The select code may change freely while clk_en is low. The code held for at least three reference cycles before clk_en rises is the starting ratio.
- R4: While enabled, a select change takes effect no later than 10 reference periods after the last select edge. From then on, output rising edges are spaced by the new ratio.
- R5: No high or low time of card_clk is shorter than half a reference period. This holds across every ratio change, including changes into and out of pass-through.
- R6: When both select bits change with a skew of at most one reference period, the change is treated as one change. The ratio coded by the intermediate value never appears.
- R7: A select value that lasts one reference period or less is ignored. A new code is adopted only after two equal synchronised samples taken one period apart.
- R8: With ext_src low, card_clk rising edges coincide with reference rising edges. With ext_src high, they coincide with reference falling edges. ext_src is changed only while clk_en is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Card clock enable from the activation sequencer |
| sel_div | input | 2 | Ratio select code, Gray ordered |
| ext_src | input | 1 | High when the reference comes from an external driver rather than a crystal |
| card_clk | output | 1 | Clock to the card |

## Verification
Corrupted divider state shows up at card_clk within one output period, in three ways: a rise-to-rise interval that does not match the coded ratio, a pulse narrower than half a reference period, or a high phase matching a ratio that was never committed. A fault in the select filtering does not show until the next live change. It then appears within about ten reference periods, either as a late switch or as a brief run of the intermediate ratio after a skewed or glitched select. A fault in the output phase stage shows on the first rising edge after enable, as card_clk rising on the wrong reference edge.

// File: rtl/ccd_pkg.sv
`timescale 1ns/1ps
package ccd_pkg;
  localparam int SEL_W     = 2;
  localparam int MAX_RATIO = 8;
  localparam int HALF_W    = $clog2(MAX_RATIO / 2);

  typedef logic [SEL_W-1:0] sel_t;

  localparam sel_t SEL_PASS = 2'b10;

  // Gray-ordered select code to division ratio
  function automatic int unsigned ratio_of(sel_t c);
    case (c)
      2'b00:   ratio_of = 8;
      2'b01:   ratio_of = 4;
      2'b11:   ratio_of = 2;
      default: ratio_of = 1;
    endcase
  endfunction

  function automatic logic is_pass(sel_t c);
    is_pass = (c == SEL_PASS);
  endfunction

  // last count value inside one half period of the divided output
  function automatic logic [HALF_W-1:0] last_count(sel_t c);
    int unsigned h;
    h = ratio_of(c) / 2;
    last_count = (h == 0) ? '0 : HALF_W'(h - 1);
  endfunction
endpackage

// File: rtl/ccd_sel_sync.sv
`timescale 1ns/1ps
module ccd_sel_sync
  import ccd_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  sel_t sel_in,
  output sel_t sel_out,
  output logic sel_stable
);
  sel_t chain [STAGES];
  sel_t prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= sel_in;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain[i] <= '0;
        else        chain[i] <= chain[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain[STAGES-1];

  assign sel_out    = chain[STAGES-1];
  assign sel_stable = (chain[STAGES-1] == prev_q);
endmodule

// File: rtl/ccd_phase_gen.sv
`timescale 1ns/1ps
module ccd_phase_gen
  import ccd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  sel_t sel_sync,
  input  logic sel_stable,
  output logic phase,
  output logic pass_on
);
  localparam int PEND_MAX = MAX_RATIO / 2;
  localparam int PEND_W   = HALF_W + 1;

  sel_t              code_q;
  logic [HALF_W-1:0] cnt_q;
  logic [PEND_W-1:0] pend_q;

  // named internal events
  logic want;
  logic boundary;
  logic commit;

  assign want     = sel_stable && (sel_sync != code_q);
  assign boundary = is_pass(code_q) || (cnt_q == last_count(code_q));
  assign commit   = en && boundary && want;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= '0;
      cnt_q   <= '0;
      phase   <= 1'b0;
      pass_on <= 1'b0;
    end else if (!en) begin
      code_q  <= sel_sync;
      cnt_q   <= '0;
      phase   <= 1'b0;
      pass_on <= 1'b0;
    end else if (commit) begin
      code_q <= sel_sync;
      cnt_q  <= '0;
      if (is_pass(sel_sync)) begin
        pass_on <= 1'b1;
        phase   <= 1'b0;
      end else begin
        pass_on <= 1'b0;
        phase   <= is_pass(code_q) ? 1'b0 : ~phase;
      end
    end else if (is_pass(code_q)) begin
      pass_on <= 1'b1;
      phase   <= 1'b0;
      cnt_q   <= '0;
    end else if (cnt_q == last_count(code_q)) begin
      cnt_q <= '0;
      phase <= ~phase;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // cycles a stable request has waited for its boundary
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             pend_q <= '0;
    else if (en && want)    pend_q <= (&pend_q) ? pend_q : pend_q + 1'b1;
    else                    pend_q <= '0;

  // R2
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(en) |-> (!phase && !pass_on));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !is_pass(code_q)) |-> (cnt_q <= last_count(code_q)));

  // R7
  code_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en) && (code_q != $past(code_q))) |-> $past(sel_stable));

  // R4
  pend_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q <= PEND_W'(PEND_MAX));

  // R5
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_on |-> !phase);
endmodule

// File: rtl/ccd_out_stage.sv
`timescale 1ns/1ps
module ccd_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_src,
  input  logic phase,
  input  logic pass_on,
  output logic card_clk
);
  logic phase_n;   // divided phase retimed to the falling edge
  logic gate_n;    // pass-through gate, changes only while clk is low

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) begin
      phase_n <= 1'b0;
      gate_n  <= 1'b0;
    end else begin
      phase_n <= phase;
      gate_n  <= pass_on;
    end

  // crystal: edges on rising reference; external: inverted, edges on falling
  assign card_clk = ext_src ? (phase_n | (~clk & pass_on))
                            : (phase   | ( clk & gate_n));
endmodule

// File: rtl/card_clk_div.sv
`timescale 1ns/1ps
module card_clk_div
  import ccd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic [SEL_W-1:0] sel_div,
  input  logic             ext_src,
  output logic             card_clk
);
  sel_t sel_sync;
  logic sel_stable;
  logic phase;
  logic pass_on;

  ccd_sel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .sel_in     (sel_div),
    .sel_out    (sel_sync),
    .sel_stable (sel_stable)
  );

  ccd_phase_gen u_phase (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .en         (clk_en),
    .sel_sync   (sel_sync),
    .sel_stable (sel_stable),
    .phase      (phase),
    .pass_on    (pass_on)
  );

  ccd_out_stage u_out (
    .clk      (clk_ref),
    .rst_n    (rst_n),
    .ext_src  (ext_src),
    .phase    (phase),
    .pass_on  (pass_on),
    .card_clk (card_clk)
  );
endmodule

// File: tb/sim_card_clk_div.sv
`timescale 1ns/1ps
module sim_card_clk_div;
  localparam real TREF = 4.0;

  logic       clk_ref = 1'b0;
  logic       rst_n   = 1'b0;
  logic       clk_en  = 1'b0;
  logic [1:0] sel_div = 2'b00;
  logic       ext_src = 1'b0;
  logic       card_clk;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(TREF/2) clk_ref = ~clk_ref;

  card_clk_div u0 (
    .clk_ref  (clk_ref),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .sel_div  (sel_div),
    .ext_src  (ext_src),
    .card_clk (card_clk)
  );

  // pulse-width monitor
  real t_edge = 0.0;
  real t_rise = 0.0;
  real min_w  = 1000.0;
  int  hi8    = 0;
  always @(card_clk) begin
    real w;
    w = $realtime - t_edge;
    if (rst_n && w < min_w) min_w = w;
    if (!card_clk && ($realtime - t_rise) > 7.99 && ($realtime - t_rise) < 8.01) hi8++;
    t_edge = $realtime;
    if (card_clk) t_rise = $realtime;
  end

  function automatic real ratio_ns(input logic [1:0] c);
    case (c)
      2'b00:   return 8.0 * TREF;
      2'b01:   return 4.0 * TREF;
      2'b11:   return 2.0 * TREF;
      default: return TREF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0.3f expected %0.3f", req, what, act, exp);
    end
  endtask

  // measure one rise-to-rise interval and the reference level at the rise
  task automatic meas(input real exp, input string req);
    real t1, d;
    @(posedge card_clk);
    t1 = $realtime;
    @(posedge card_clk);
    d = $realtime - t1;
    chk((d - exp) < 0.01 && (exp - d) < 0.01, req, "period", d, exp);
    chk(clk_ref == !ext_src, "R8", "reference level at card_clk rise",
        real'(clk_ref), real'(!ext_src));
  endtask

  task automatic width_ok(input string req);
    chk(min_w > 1.999, req, "minimum pulse width", min_w, TREF/2);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk_ref);
    #1 chk(card_clk == 1'b0, "R2", "card_clk in reset", real'(card_clk), 0.0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_ref);
    #1 chk(card_clk == 1'b0, "R2", "card_clk idle after reset", real'(card_clk), 0.0);
  endtask

  task automatic t_start(input logic [1:0] c, input logic ext);
    @(negedge clk_ref);
    clk_en = 1'b0;
    repeat (2) @(negedge clk_ref);
    ext_src = ext;
    sel_div = c;
    repeat (4) @(negedge clk_ref);
    clk_en = 1'b1;
    @(posedge card_clk);
    meas(ratio_ns(c), "R1");
  endtask

  task automatic t_churn();
    @(negedge clk_ref);
    clk_en = 1'b0;
    ext_src = 1'b0;
    for (int i = 0; i < 4; i++) begin
      sel_div = 2'(i);
      repeat (2) @(negedge clk_ref);
    end
    sel_div = 2'b01;
    repeat (4) @(negedge clk_ref);
    clk_en = 1'b1;
    @(posedge card_clk);
    meas(ratio_ns(2'b01), "R3");
  endtask

  task automatic t_live(input logic [1:0] c);
    min_w = 1000.0;
    @(negedge clk_ref);
    sel_div = c;
    repeat (10) @(negedge clk_ref);
    meas(ratio_ns(c), "R4");
    meas(ratio_ns(c), "R4");
    width_ok("R5");
  endtask

  task automatic t_skew();
    t_start(2'b00, 1'b0);
    hi8 = 0;
    @(negedge clk_ref);
    sel_div[0] = 1'b1;
    @(negedge clk_ref);
    sel_div[1] = 1'b1;
    repeat (30) @(negedge clk_ref);
    chk(hi8 == 0, "R6", "pulses at intermediate ratio", real'(hi8), 0.0);
    meas(ratio_ns(2'b11), "R6");
  endtask

  task automatic t_glitch();
    t_start(2'b00, 1'b0);
    hi8 = 0;
    @(negedge clk_ref);
    sel_div[0] = 1'b1;
    @(negedge clk_ref);
    sel_div[0] = 1'b0;
    repeat (30) @(negedge clk_ref);
    chk(hi8 == 0, "R7", "pulses at glitch ratio", real'(hi8), 0.0);
    meas(ratio_ns(2'b00), "R7");
  endtask

  task automatic t_disable();
    int highs;
    highs = 0;
    @(negedge clk_ref);
    clk_en = 1'b0;
    repeat (2) @(negedge clk_ref);
    for (int i = 0; i < 16; i++) begin
      #1 if (card_clk) highs++;
      #1;
    end
    chk(highs == 0, "R2", "high samples while disabled", real'(highs), 0.0);
  endtask

  initial begin
    #(200000 * TREF);
    if (!done) begin
      chk(1'b0, "WATCHDOG", "run did not finish", 1.0, 0.0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    // R1 R8: every code, crystal phase
    t_start(2'b00, 1'b0);
    t_start(2'b01, 1'b0);
    t_start(2'b11, 1'b0);
    t_start(2'b10, 1'b0);
    // R1 R8: inverted phase for external reference
    t_start(2'b00, 1'b1);
    t_start(2'b10, 1'b1);
    t_disable();
    t_churn();
    // R4 R5: live changes, crystal, through pass-through
    t_start(2'b00, 1'b0);
    t_live(2'b10);
    t_live(2'b11);
    t_live(2'b00);
    // R4 R5: live changes, external
    t_start(2'b11, 1'b1);
    t_live(2'b10);
    t_live(2'b00);
    t_live(2'b01);
    t_skew();
    t_glitch();
    t_disable();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule